// File: doc/BRIEF.md
# Masked Dual Alarm Comparator

This block watches a running time-of-day and calendar value and compares it against two alarm settings, each held outside the block. An alarm setting has six calendar fields: second, minute, hour, day of month, month and weekday. A six-bit enable vector belongs to each alarm and chooses which fields take part in the comparison. The compare runs only on a one-cycle 1 Hz strobe. An alarm fires when that strobe arrives, the alarm is armed, at least one field is enabled and every enabled field equals the current value. A fired alarm sets its own status flag, which stays set until the host clears it.

The host polls the flags to learn which alarm went off. Each alarm also has an interrupt enable, and the single active-low interrupt line is pulled low while any flag that has its interrupt enabled is set. Each alarm runs in one of two modes. In one-shot mode it disarms itself when it fires. In repeat mode it stays armed and fires again on every matching second. A one-cycle arm strobe re-arms an alarm. The block has no data stream, so every pin is a plain control or status level or strobe.

Top module: `alarm_cmp_dual`

## Requirements
- R1: After reset, both flags read 0, irq_n_o reads 1 and both alarms are disarmed. A disarmed alarm never sets its flag, even when its fields match on a tick.
- R2: The calendar vector is packed as {weekday[28:26], month[25:22], date[21:17], hour[16:12], minute[11:6], second[5:0]}, and enable bit k selects field k in that order from bit 0 (second) to bit 5 (weekday). An armed alarm whose enabled fields all equal now_i when tick_i is high sets its flag on that clock edge, so the flag reads 1 in the following cycle.
- R3: A field whose enable bit is 0 is ignored. A mismatch in that field does not stop the alarm from firing.
- R4: An alarm whose six enable bits are all 0 never fires.
- R5: Without tick_i, no flag rises, even when the fields match and the alarm is armed.
- R6: A flag stays set until its clr_i bit is pulsed. If a clear and a fire fall in the same cycle, the flag ends up set.
- R7: With repeat_i low, a firing disarms the alarm, so later matching ticks leave its flag clear until arm_i is pulsed.
- R8: With repeat_i high, the alarm stays armed and sets its flag on every matching tick.
- R9: irq_n_o is 0 exactly when some alarm has both its flag and its irq_en_i bit set. It follows flag_o and irq_en_i in the same cycle.
- R10: The two alarms act independently. Alarm a uses slice a of the packed inputs, and clearing one flag leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle 1 Hz compare strobe |
| now_i | input | 29 | Current calendar value, packed as in R2 |
| alm_val_i | input | 58 | Alarm settings, alarm a in bits [29a+28:29a] |
| alm_en_i | input | 12 | Field enables, alarm a in bits [6a+5:6a] |
| repeat_i | input | 2 | Repeat mode per alarm |
| irq_en_i | input | 2 | Interrupt enable per alarm |
| arm_i | input | 2 | One-cycle arm strobe per alarm |
| clr_i | input | 2 | One-cycle flag clear strobe per alarm |
| flag_o | output | 2 | Sticky alarm status flags |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
Each flag comes from one register, so a tick, clear or arm strobe driven before a rising edge shows its effect on flag_o right after that edge. The interrupt line is combinational from the flags and enables, so it shows the same-cycle value. The bench drives every strobe for exactly one cycle starting at a falling edge and samples at the next falling edge, halfway between the edge that updated the register and the following one. The sweep over all 64 enable vectors crossed with all 64 field-mismatch patterns is checked against an expected value computed from R2 to R4 alone. The interrupt changes in R9 are sampled a short delay after the enable bit is driven, with no clock edge in between.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  parameter int SEC_W  = 6;
  parameter int MIN_W  = 6;
  parameter int HOUR_W = 5;
  parameter int DATE_W = 5;
  parameter int MON_W  = 4;
  parameter int DOW_W  = 3;

  localparam int NUM_FIELDS = 6;
  localparam int FW [NUM_FIELDS] = '{SEC_W, MIN_W, HOUR_W, DATE_W, MON_W, DOW_W};

  // Lowest bit of field k inside the packed calendar vector.
  function automatic int field_lsb(input int k);
    int s;
    s = 0;
    for (int j = 0; j < k; j++) s += FW[j];
    return s;
  endfunction

  localparam int CAL_W = field_lsb(NUM_FIELDS);
endpackage

// File: rtl/alarm_field_match.sv
module alarm_field_match
  import alarm_cmp_pkg::*;
(
  input  logic [CAL_W-1:0]      now_i,
  input  logic [CAL_W-1:0]      alm_i,
  input  logic [NUM_FIELDS-1:0] en_i,
  output logic                  hit_o
);
  logic [NUM_FIELDS-1:0] eq;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
    localparam int LSB = field_lsb(k);
    localparam int W   = FW[k];
    assign eq[k] = (now_i[LSB +: W] == alm_i[LSB +: W]);
  end

  // A masked field counts as a match; a fully masked alarm never hits.
  assign hit_o = (|en_i) && (&(eq | ~en_i));
endmodule

// File: rtl/alarm_channel.sv
module alarm_channel (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic hit_i,
  input  logic arm_i,
  input  logic clr_i,
  input  logic repeat_i,
  output logic flag_o
);
  logic armed_q;
  logic flag_q;
  logic fire;

  assign fire = tick_i && armed_q && hit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
    end else if (fire && !repeat_i) begin
      armed_q <= 1'b0;
    end
  end

  // A new firing outranks a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (fire) begin
      flag_q <= 1'b1;
    end else if (clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/alarm_cmp_dual.sv
module alarm_cmp_dual
  import alarm_cmp_pkg::*;
#(
  parameter int NUM_ALARMS = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             tick_i,
  input  logic [CAL_W-1:0]                 now_i,
  input  logic [NUM_ALARMS*CAL_W-1:0]      alm_val_i,
  input  logic [NUM_ALARMS*NUM_FIELDS-1:0] alm_en_i,
  input  logic [NUM_ALARMS-1:0]            repeat_i,
  input  logic [NUM_ALARMS-1:0]            irq_en_i,
  input  logic [NUM_ALARMS-1:0]            arm_i,
  input  logic [NUM_ALARMS-1:0]            clr_i,
  output logic [NUM_ALARMS-1:0]            flag_o,
  output logic                             irq_n_o
);
  logic [NUM_ALARMS-1:0] hit;

  for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
    alarm_field_match u_match (
      .now_i (now_i),
      .alm_i (alm_val_i[a*CAL_W +: CAL_W]),
      .en_i  (alm_en_i[a*NUM_FIELDS +: NUM_FIELDS]),
      .hit_o (hit[a])
    );

    alarm_channel u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .hit_i    (hit[a]),
      .arm_i    (arm_i[a]),
      .clr_i    (clr_i[a]),
      .repeat_i (repeat_i[a]),
      .flag_o   (flag_o[a])
    );
  end

  assign irq_n_o = ~|(flag_o & irq_en_i);
endmodule

// File: rtl/alarm_cmp_dual_chk.sv
module alarm_cmp_dual_chk
  import alarm_cmp_pkg::*;
#(
  parameter int NUM_ALARMS = 2
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             tick_i,
  input logic [NUM_ALARMS*NUM_FIELDS-1:0] alm_en_i,
  input logic [NUM_ALARMS-1:0]            irq_en_i,
  input logic [NUM_ALARMS-1:0]            clr_i,
  input logic [NUM_ALARMS-1:0]            flag_o,
  input logic                             irq_n_o
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (flag_o == '0 && irq_n_o));

  a_r5_no_tick_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> ((flag_o & ~$past(flag_o)) == '0));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o & ~clr_i) != '0 |=> (($past(flag_o & ~clr_i) & ~flag_o) == '0));

  a_r9_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o |-> ((flag_o & irq_en_i) != '0));

  a_r9_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n_o |-> ((flag_o & irq_en_i) == '0));

  for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_chk
    a_r4_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_en_i[a*NUM_FIELDS +: NUM_FIELDS] == '0 && !flag_o[a]) |=> !flag_o[a]);
  end
endmodule

bind alarm_cmp_dual alarm_cmp_dual_chk #(.NUM_ALARMS(NUM_ALARMS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_i   (tick_i),
  .alm_en_i (alm_en_i),
  .irq_en_i (irq_en_i),
  .clr_i    (clr_i),
  .flag_o   (flag_o),
  .irq_n_o  (irq_n_o)
);

// File: tb/alarm_cmp_dual_tb.sv
module alarm_cmp_dual_tb;
  import alarm_cmp_pkg::*;

  localparam int N = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick_i = 1'b0;
  logic [CAL_W-1:0]  now_i = '0;
  logic [N*CAL_W-1:0] alm_val_i = '0;
  logic [N*6-1:0]    alm_en_i = '0;
  logic [N-1:0]      repeat_i = '0;
  logic [N-1:0]      irq_en_i = '0;
  logic [N-1:0]      arm_i = '0;
  logic [N-1:0]      clr_i = '0;
  logic [N-1:0]      flag_o;
  logic              irq_n_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  alarm_cmp_dual #(.NUM_ALARMS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .now_i(now_i),
    .alm_val_i(alm_val_i), .alm_en_i(alm_en_i), .repeat_i(repeat_i),
    .irq_en_i(irq_en_i), .arm_i(arm_i), .clr_i(clr_i),
    .flag_o(flag_o), .irq_n_o(irq_n_o)
  );

  function automatic logic [28:0] pack(int s, int m, int h, int d, int mo, int w);
    return {w[2:0], mo[3:0], d[4:0], h[4:0], m[5:0], s[5:0]};
  endfunction

  // Field lsbs per the R2 layout: 0, 6, 12, 17, 22, 26.
  function automatic logic [28:0] flip(logic [28:0] c, logic [5:0] mm);
    int lsb [6] = '{0, 6, 12, 17, 22, 26};
    logic [28:0] r;
    r = c;
    for (int k = 0; k < 6; k++) if (mm[k]) r[lsb[k]] = ~r[lsb[k]];
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(logic [N-1:0] arm, logic [N-1:0] clr, logic tk);
    @(negedge clk);
    arm_i = arm; clr_i = clr; tick_i = tk;
    @(negedge clk);
    arm_i = '0; clr_i = '0; tick_i = 1'b0;
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [28:0] t0;
    logic        exp;
    t0 = pack(37, 12, 21, 17, 9, 4);
    now_i = t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flags", 32'(flag_o), 0);
    chk("R1 irq", 32'(irq_n_o), 1);

    // R1: disarmed alarm ignores a full match.
    alm_val_i[28:0] = t0; alm_en_i[5:0] = 6'h3F; irq_en_i = 2'b01;
    strobe('0, '0, 1'b1);
    chk("R1 disarmed", 32'(flag_o), 0);

    // R5: armed and matching but no tick.
    strobe(2'b01, '0, 1'b0);
    repeat (5) @(negedge clk);
    chk("R5 no tick", 32'(flag_o), 0);

    // R2 fire, then R6 stickiness.
    strobe('0, '0, 1'b1);
    chk("R2 fire", 32'(flag_o), 1);
    chk("R9 irq low", 32'(irq_n_o), 0);
    alm_val_i[28:0] = flip(t0, 6'h01);
    strobe('0, '0, 1'b1);
    repeat (3) @(negedge clk);
    chk("R6 held", 32'(flag_o), 1);
    strobe('0, 2'b01, 1'b0);
    chk("R6 cleared", 32'(flag_o), 0);

    // R7: one-shot disarmed after firing.
    alm_val_i[28:0] = t0;
    strobe('0, '0, 1'b1);
    chk("R7 disarmed", 32'(flag_o), 0);
    strobe(2'b01, '0, 1'b0);
    strobe('0, 2'b01, 1'b1);  // R6: clear and fire in one cycle
    chk("R6 fire beats clear", 32'(flag_o), 1);
    strobe('0, '0, 1'b1);
    chk("R7 single fire", 32'(flag_o), 1);
    strobe('0, 2'b01, 1'b0);
    strobe('0, '0, 1'b1);
    chk("R7 stays disarmed", 32'(flag_o), 0);

    // R8: repeat mode keeps firing.
    repeat_i = 2'b01;
    strobe(2'b01, '0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      strobe('0, '0, 1'b1);
      chk("R8 repeat fire", 32'(flag_o), 1);
      strobe('0, 2'b01, 1'b0);
      chk("R8 repeat clear", 32'(flag_o), 0);
    end
    repeat_i = '0;

    // R9: interrupt gating, same cycle.
    strobe(2'b01, '0, 1'b1);
    strobe('0, '0, 1'b1);
    irq_en_i = 2'b00; #1;
    chk("R9 gated off", 32'(irq_n_o), 1);
    irq_en_i = 2'b01; #1;
    chk("R9 gated on", 32'(irq_n_o), 0);
    strobe('0, 2'b01, 1'b0);

    // R10: independent alarms.
    alm_val_i[57:29] = t0; alm_en_i[11:6] = 6'h3F;
    alm_val_i[28:0] = flip(t0, 6'h08);
    strobe(2'b11, '0, 1'b0);
    strobe('0, '0, 1'b1);
    chk("R10 only alarm1", 32'(flag_o), 2);
    alm_val_i[28:0] = t0;
    strobe('0, '0, 1'b1);
    chk("R10 both", 32'(flag_o), 3);
    strobe('0, 2'b10, 1'b0);
    chk("R10 clear one", 32'(flag_o), 1);
    strobe('0, 2'b01, 1'b0);
    alm_en_i[11:6] = '0;

    // R2/R3/R4 sweep: every enable vector against every mismatch pattern.
    irq_en_i = 2'b01;
    for (int mm = 0; mm < 64; mm++) begin
      for (int m = 0; m < 64; m++) begin
        alm_en_i[5:0] = 6'(m);
        alm_val_i[28:0] = flip(t0, 6'(mm));
        strobe(2'b01, 2'b01, 1'b0);
        strobe('0, '0, 1'b1);
        exp = (m != 0) && ((m & mm) == 0);
        if (m == 0)              chk("R4 all masked", 32'(flag_o[0]), 32'(exp));
        else if ((mm & ~m) != 0) chk("R3 masked mismatch", 32'(flag_o[0]), 32'(exp));
        else                     chk("R2 compare", 32'(flag_o[0]), 32'(exp));
        chk("R9 sweep irq", 32'(irq_n_o), 32'(!exp));
      end
    end

    finish_run();
  end
endmodule